// File: doc/BRIEF.md
# Event Permission Filter and ID Reporter

This block decides which event numbers a set of performance counters is allowed to count. It holds one permission bit per event number and exposes three ports. The first takes range commands made of a start event, a length and an action (allow or deny), and returns a response code. The second takes an event number and answers, one cycle later, whether that event is permitted. The third builds a 64-bit event-ID word from an implemented-events value supplied by the caller, masked with the permission bits.

Until the first range command is accepted there is no filter: every lookup reports "permitted" and ID words pass through with only their fixed adjustments. The first accepted command decides what the rest of the space defaults to. An allow makes every other event denied, and a deny makes every other event permitted. Each accepted command rewrites the bitmap one 32-event word per cycle. While it does so, `cmd_ready` is low, and each lookup sees either the old or the new content of each word. Once the `run_started` input is high, every command is refused.

Top module: `evt_perm_filter`

## Requirements
- R1: After reset `cmd_ready` is 1, `rsp_valid` and `lk_rsp_valid` are 0, and while no command has been accepted every lookup returns `lk_allow` = 1.
- R2: A command whose start plus length exceeds the event count (2^EVT_LOG2), or whose action code is neither 0 (allow) nor 1 (deny), gets response code 1 (invalid), even if `run_started` is high, and changes no permission bit.
- R3: A well-formed command while `run_started` is 1 gets response code 2 (refused) and changes no permission bit; an accepted command gets code 0.
- R4: When the first accepted command is an allow, every event outside its range becomes denied and every event inside it becomes permitted.
- R5: When the first accepted command is a deny, every event outside its range becomes permitted and every event inside it becomes denied.
- R6: A later allow sets the bits of events in [start, start+length) and a later deny clears them. Bits outside that range keep their value, and a length of zero changes nothing. A range may end exactly at the last event.
- R7: After an accepted command `cmd_ready` stays low for one cycle per bitmap word rewritten: all 2^EVT_LOG2/32 words for the first command, and the words from the start word to the word holding start+length-1 for later ones (none for zero length or a rejected command).
- R8: `rsp_valid` is high in the cycle after a command is taken, and `lk_rsp_valid` is high in the cycle after `lk_req`, with `lk_allow` = the permission bit of `lk_event`.
- R9: ID selector 0 returns the supplied value with bit 30 (the chaining event) forced to 1. Selector 1 returns it with bits 29, 30 and 31 (the three slot-stall events) forced to 0. The response comes one cycle after `id_req`.
- R10: Once a filter exists, bits 31:0 of the ID result are ANDed with the permission bits of events 32*sel .. 32*sel+31. Bits 63:32 are ANDed with events 0x4000+32*sel onward, but only when the event count is at least 0x4000+32*sel+32; otherwise they are 0. Without a filter both halves pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_started | input | 1 | When high, commands are refused |
| cmd_valid | input | 1 | Range command present |
| cmd_ready | output | 1 | Block can take a command (no rewrite in progress) |
| cmd_base | input | EVT_LOG2+1 | First event of the range |
| cmd_count | input | EVT_LOG2+1 | Number of events in the range |
| cmd_action | input | 2 | 0 allow, 1 deny, others invalid |
| rsp_valid | output | 1 | Response code valid |
| rsp_code | output | 2 | 0 accepted, 1 invalid, 2 refused |
| lk_req | input | 1 | Lookup request |
| lk_event | input | EVT_LOG2 | Event number to look up |
| lk_rsp_valid | output | 1 | Lookup answer valid |
| lk_allow | output | 1 | Event is permitted |
| id_req | input | 1 | ID word request |
| id_sel | input | 1 | Selects ID word 0 or 1 |
| id_impl | input | 64 | Implemented-events value to be masked |
| id_rsp_valid | output | 1 | ID result valid |
| id_word | output | 64 | Masked ID result |

## Verification
The bench aims at the first-command fill. A design that skipped the fill, or used the wrong polarity for it, would leave events far from the range with the wrong answer. It also probes the edges of each range: the event before the start, the start itself, the last event, and the one after. These catch off-by-one comparisons, ranges that cross a word boundary, and a range ending exactly at the last event, which an overflowing sum check would reject. It checks that invalid and refused commands leave the filter untouched. It counts busy cycles, so a design that rewrote the wrong number of words shows up. Finally, it reads both ID words with and without a filter, including the high half, so a misplaced chaining or stall bit or a wrong high-range offset changes the result.

// File: rtl/evf_pkg.sv
package evf_pkg;
  localparam logic [1:0] ACT_ALLOW   = 2'd0;
  localparam logic [1:0] ACT_DENY    = 2'd1;
  localparam logic [1:0] RSP_OK      = 2'd0;
  localparam logic [1:0] RSP_INVALID = 2'd1;
  localparam logic [1:0] RSP_REFUSED = 2'd2;
  localparam int WORD_W      = 32;
  localparam int CHAIN_BIT   = 30;
  localparam int STALL_LSB   = 29;
  localparam int HI_EVT_BASE = 16'h4000;
endpackage

// File: rtl/evf_cmd_engine.sv
module evf_cmd_engine
  import evf_pkg::*;
#(
  parameter int EVT_LOG2 = 10,
  localparam int NUM_EV = 1 << EVT_LOG2,
  localparam int WA = EVT_LOG2 - 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run_started,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [EVT_LOG2:0]   cmd_base,
  input  logic [EVT_LOG2:0]   cmd_count,
  input  logic [1:0]          cmd_action,
  output logic                rsp_valid,
  output logic [1:0]          rsp_code,
  output logic                wr_en,
  output logic [WA-1:0]       wr_addr,
  output logic [WORD_W-1:0]   wr_data,
  input  logic [WORD_W-1:0]   rmw_data,
  output logic                filt_valid
);
  logic                busy, fill, act_deny;
  logic [EVT_LOG2:0]   lo;
  logic [EVT_LOG2+1:0] hi;
  logic [WA-1:0]       cur, last;
  logic [EVT_LOG2+1:0] sum, sum_m1;
  logic                bad, accept, go_ok, start_fill, start_rng;
  logic [WORD_W-1:0]   hit, seed;

  function automatic logic in_range(input logic [WA-1:0] w, input int b,
                                    input logic [EVT_LOG2:0] l,
                                    input logic [EVT_LOG2+1:0] h);
    logic [EVT_LOG2+1:0] idx;
    idx = {2'b00, w, 5'(b)};
    return (idx >= {1'b0, l}) && (idx < h);
  endfunction

  assign sum        = {1'b0, cmd_base} + {1'b0, cmd_count};
  assign sum_m1     = sum - 1'b1;
  assign bad        = (sum > (EVT_LOG2+2)'(NUM_EV)) ||
                      ((cmd_action != ACT_ALLOW) && (cmd_action != ACT_DENY));
  assign accept     = cmd_valid && !busy;
  assign go_ok      = accept && !bad && !run_started;
  assign start_fill = go_ok && !filt_valid;
  assign start_rng  = go_ok && filt_valid && (cmd_count != '0);
  assign cmd_ready  = !busy;

  always_comb begin
    for (int b = 0; b < WORD_W; b++) hit[b] = in_range(cur, b, lo, hi);
  end

  assign seed    = fill ? (act_deny ? '1 : '0) : rmw_data;
  assign wr_en   = busy;
  assign wr_addr = cur;
  assign wr_data = act_deny ? (seed & ~hit) : (seed | hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      fill       <= 1'b0;
      act_deny   <= 1'b0;
      lo         <= '0;
      hi         <= '0;
      cur        <= '0;
      last       <= '0;
      rsp_valid  <= 1'b0;
      rsp_code   <= RSP_OK;
      filt_valid <= 1'b0;
    end else begin
      rsp_valid <= accept;
      if (accept)
        rsp_code <= bad ? RSP_INVALID : (run_started ? RSP_REFUSED : RSP_OK);
      if (start_fill || start_rng) begin
        busy     <= 1'b1;
        fill     <= start_fill;
        act_deny <= (cmd_action == ACT_DENY);
        lo       <= cmd_base;
        hi       <= sum;
        cur      <= start_fill ? '0 : cmd_base[EVT_LOG2-1:5];
        last     <= start_fill ? '1 : sum_m1[EVT_LOG2-1:5];
      end else if (busy) begin
        if (cur == last) begin
          busy <= 1'b0;
          if (fill) filt_valid <= 1'b1;
        end else begin
          cur <= cur + 1'b1;
        end
      end
    end
  end

  p_run_refused_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && !bad && run_started) |=> (rsp_valid && rsp_code == RSP_REFUSED));
  p_bad_invalid_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && bad) |=> (rsp_valid && rsp_code == RSP_INVALID));
  p_reject_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code != RSP_OK) |-> cmd_ready);
  p_valid_at_end_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(filt_valid) |-> ($past(busy) && cmd_ready));
endmodule

// File: rtl/evf_bitmap_store.sv
module evf_bitmap_store
  import evf_pkg::*;
#(
  parameter int EVT_LOG2 = 10,
  localparam int NUM_EV = 1 << EVT_LOG2,
  localparam int WA = EVT_LOG2 - 5,
  localparam int WORDS = NUM_EV / WORD_W,
  localparam int HI_W = HI_EVT_BASE / WORD_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [WA-1:0]       wr_addr,
  input  logic [WORD_W-1:0]   wr_data,
  output logic [WORD_W-1:0]   rmw_data,
  input  logic                filt_valid,
  input  logic                lk_req,
  input  logic [EVT_LOG2-1:0] lk_event,
  output logic                lk_rsp_valid,
  output logic                lk_allow,
  output logic [WORD_W-1:0]   id_lo0,
  output logic [WORD_W-1:0]   id_lo1,
  output logic [WORD_W-1:0]   id_hi0,
  output logic [WORD_W-1:0]   id_hi1
);
  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rmw_data = mem[wr_addr];
  assign id_lo0   = mem[0];
  assign id_lo1   = mem[1];

  generate
    if (NUM_EV >= HI_EVT_BASE + WORD_W) begin : g_hi0
      assign id_hi0 = mem[HI_W];
    end else begin : g_no_hi0
      assign id_hi0 = '0;
    end
    if (NUM_EV >= HI_EVT_BASE + 2 * WORD_W) begin : g_hi1
      assign id_hi1 = mem[HI_W + 1];
    end else begin : g_no_hi1
      assign id_hi1 = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_rsp_valid <= 1'b0;
      lk_allow     <= 1'b1;
    end else begin
      lk_rsp_valid <= lk_req;
      if (lk_req)
        lk_allow <= !filt_valid || mem[lk_event[EVT_LOG2-1:5]][lk_event[4:0]];
    end
  end

  p_prefilter_permit_r1: assert property (@(posedge clk) disable iff (rst)
    (lk_req && !filt_valid) |=> (lk_rsp_valid && lk_allow));
endmodule

// File: rtl/evf_id_builder.sv
module evf_id_builder
  import evf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              id_req,
  input  logic              id_sel,
  input  logic [63:0]       id_impl,
  input  logic              filt_valid,
  input  logic [WORD_W-1:0] id_lo0,
  input  logic [WORD_W-1:0] id_lo1,
  input  logic [WORD_W-1:0] id_hi0,
  input  logic [WORD_W-1:0] id_hi1,
  output logic              id_rsp_valid,
  output logic [63:0]       id_word
);
  logic [63:0] raw, msk;

  assign raw = id_sel ? (id_impl & ~(64'h7 << STALL_LSB))
                      : (id_impl | (64'h1 << CHAIN_BIT));
  assign msk = id_sel ? {id_hi1, id_lo1} : {id_hi0, id_lo0};

  always_ff @(posedge clk) begin
    if (rst) begin
      id_rsp_valid <= 1'b0;
      id_word      <= '0;
    end else begin
      id_rsp_valid <= id_req;
      if (id_req) id_word <= filt_valid ? (raw & msk) : raw;
    end
  end

  p_chain_shown_r9: assert property (@(posedge clk) disable iff (rst)
    (id_req && !id_sel && !filt_valid) |=> (id_rsp_valid && id_word[CHAIN_BIT]));
  p_stall_hidden_r9: assert property (@(posedge clk) disable iff (rst)
    (id_req && id_sel) |=> (id_word[STALL_LSB+2:STALL_LSB] == 3'b000));
endmodule

// File: rtl/evt_perm_filter.sv
module evt_perm_filter
  import evf_pkg::*;
#(
  parameter int EVT_LOG2 = 10,
  localparam int WA = EVT_LOG2 - 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run_started,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [EVT_LOG2:0]   cmd_base,
  input  logic [EVT_LOG2:0]   cmd_count,
  input  logic [1:0]          cmd_action,
  output logic                rsp_valid,
  output logic [1:0]          rsp_code,
  input  logic                lk_req,
  input  logic [EVT_LOG2-1:0] lk_event,
  output logic                lk_rsp_valid,
  output logic                lk_allow,
  input  logic                id_req,
  input  logic                id_sel,
  input  logic [63:0]         id_impl,
  output logic                id_rsp_valid,
  output logic [63:0]         id_word
);
  logic              wr_en, filt_valid;
  logic [WA-1:0]     wr_addr;
  logic [WORD_W-1:0] wr_data, rmw_data, lo0, lo1, hi0, hi1;

  evf_cmd_engine #(.EVT_LOG2(EVT_LOG2)) u_eng (
    .clk(clk), .rst(rst), .run_started(run_started),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_base(cmd_base),
    .cmd_count(cmd_count), .cmd_action(cmd_action),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rmw_data(rmw_data), .filt_valid(filt_valid)
  );

  evf_bitmap_store #(.EVT_LOG2(EVT_LOG2)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rmw_data(rmw_data), .filt_valid(filt_valid),
    .lk_req(lk_req), .lk_event(lk_event), .lk_rsp_valid(lk_rsp_valid),
    .lk_allow(lk_allow), .id_lo0(lo0), .id_lo1(lo1), .id_hi0(hi0), .id_hi1(hi1)
  );

  evf_id_builder u_id (
    .clk(clk), .rst(rst), .id_req(id_req), .id_sel(id_sel),
    .id_impl(id_impl), .filt_valid(filt_valid),
    .id_lo0(lo0), .id_lo1(lo1), .id_hi0(hi0), .id_hi1(hi1),
    .id_rsp_valid(id_rsp_valid), .id_word(id_word)
  );
endmodule

// File: tb/evt_perm_filter_tb_top.sv
module evt_perm_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int EVT_LOG2 = 15;
  localparam int NUM_EV = 1 << EVT_LOG2;
  localparam int WORDS = NUM_EV / 32;
  localparam int WD_CYCLES = 100000;

  typedef struct packed {
    logic [15:0] base;
    logic [15:0] count;
    logic [1:0]  act;
    logic [1:0]  code;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{16'd40,    16'd10, 2'd0, 2'd0},  // R4 first command, allow
    '{16'h4003,  16'd5,  2'd0, 2'd0},  // R6 high range allow
    '{16'd45,    16'd2,  2'd1, 2'd0},  // R6 deny inside earlier range
    '{16'd100,   16'd0,  2'd1, 2'd0},  // R6 zero length
    '{16'd32700, 16'd68, 2'd0, 2'd0},  // R6 ends at last event
    '{16'd32700, 16'd69, 2'd0, 2'd1},  // R2 one past the end
    '{16'd31,    16'd2,  2'd0, 2'd0},  // R6 crosses a word boundary
    '{16'd0,     16'd1,  2'd3, 2'd1}   // R2 bad action code
  };

  logic clk = 1'b0, rst = 1'b1, run_started = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [EVT_LOG2:0] cmd_base = '0, cmd_count = '0;
  logic [1:0] cmd_action = '0, rsp_code;
  logic rsp_valid, lk_req = 1'b0, lk_rsp_valid, lk_allow;
  logic [EVT_LOG2-1:0] lk_event = '0;
  logic id_req = 1'b0, id_sel = 1'b0, id_rsp_valid;
  logic [63:0] id_impl = '0, id_word;

  int checks = 0, errors = 0;
  bit model [NUM_EV];
  bit model_valid = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_perm_filter #(.EVT_LOG2(EVT_LOG2)) dut_i (
    .clk(clk), .rst(rst), .run_started(run_started),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_base(cmd_base),
    .cmd_count(cmd_count), .cmd_action(cmd_action),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .lk_req(lk_req), .lk_event(lk_event), .lk_rsp_valid(lk_rsp_valid),
    .lk_allow(lk_allow), .id_req(id_req), .id_sel(id_sel),
    .id_impl(id_impl), .id_rsp_valid(id_rsp_valid), .id_word(id_word)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_valid = 1'b0;
  endtask

  task automatic do_cmd(input int base, input int count, input int act,
                        output int code, output int nbusy);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_base = base[EVT_LOG2:0];
    cmd_count = count[EVT_LOG2:0]; cmd_action = act[1:0];
    @(negedge clk);
    cmd_valid = 1'b0;
    code = rsp_valid ? int'(rsp_code) : 99;
    nbusy = 0;
    while (!cmd_ready) begin nbusy++; @(negedge clk); end
  endtask

  task automatic do_lk(input int ev, output int res);
    @(negedge clk);
    lk_req = 1'b1; lk_event = ev[EVT_LOG2-1:0];
    @(negedge clk);
    lk_req = 1'b0;
    res = lk_rsp_valid ? int'(lk_allow) : 2;
  endtask

  task automatic do_id(input bit sel, input logic [63:0] impl, output logic [63:0] w, output bit v);
    @(negedge clk);
    id_req = 1'b1; id_sel = sel; id_impl = impl;
    @(negedge clk);
    id_req = 1'b0;
    w = id_word; v = id_rsp_valid;
  endtask

  function automatic int model_words(input int base, input int count);
    if (!model_valid) return WORDS;
    if (count == 0) return 0;
    return ((base + count - 1) / 32) - (base / 32) + 1;
  endfunction

  task automatic model_apply(input int base, input int count, input int act);
    if (!model_valid) begin
      for (int i = 0; i < NUM_EV; i++) model[i] = (act == 1);
      model_valid = 1'b1;
    end
    for (int i = base; i < base + count; i++) model[i] = (act == 0);
  endtask

  function automatic logic [63:0] model_id(input bit sel, input logic [63:0] impl);
    logic [63:0] raw, m;
    raw = sel ? (impl & ~(64'h7 << 29)) : (impl | (64'h1 << 30));
    if (!model_valid) return raw;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      m[i] = model[32*sel + i];
      if (NUM_EV >= 16'h4000 + 32*sel + 32) m[32+i] = model[16'h4000 + 32*sel + i];
    end
    return raw & m;
  endfunction

  task automatic probe(input int ev, input string req);
    int r;
    if (ev < 0 || ev >= NUM_EV) return;
    do_lk(ev, r);
    chk(r == int'(model_valid ? model[ev] : 1'b1), req, r, model_valid ? model[ev] : 1);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog expired actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int code, nb, r;
    logic [63:0] w;
    bit v;

    do_reset();
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
    chk(lk_rsp_valid == 1'b0, "R1 no lookup answer after reset", lk_rsp_valid, 0);
    probe(0, "R1 permit before filter");
    probe(NUM_EV - 1, "R1 permit last before filter");

    do_lk(77, r);
    chk(r == 1, "R8 lookup answers next cycle", r, 1);
    @(negedge clk);
    chk(lk_rsp_valid == 1'b0, "R8 answer lasts one cycle", lk_rsp_valid, 0);

    do_id(1'b0, 64'h0, w, v);
    chk(v && w == 64'h0000_0000_4000_0000, "R9 word0 no filter", w, 64'h4000_0000);
    do_id(1'b1, '1, w, v);
    chk(v && w == 64'hFFFF_FFFF_1FFF_FFFF, "R10 word1 passthrough no filter", w, 64'hFFFF_FFFF_1FFF_FFFF);

    // invalid wins over refused
    run_started = 1'b1;
    do_cmd(NUM_EV - 8, 9, 0, code, nb);
    chk(code == 1, "R2 range past end with run high", code, 1);
    chk(nb == 0, "R7 no rewrite on rejection", nb, 0);
    do_cmd(10, 5, 0, code, nb);
    chk(code == 2, "R3 refused when run started", code, 2);
    run_started = 1'b0;
    probe(10, "R3 no filter made by refused command");
    probe(5000, "R2 no filter made by invalid command");

    for (int k = 0; k < 8; k++) begin
      int b, c, a, ew;
      b = int'(VEC[k].base); c = int'(VEC[k].count); a = int'(VEC[k].act);
      ew = (VEC[k].code == 2'd0) ? model_words(b, c) : 0;
      do_cmd(b, c, a, code, nb);
      chk(code == int'(VEC[k].code), $sformatf("R2 R3 vector %0d code", k), code, VEC[k].code);
      chk(nb == ew, $sformatf("R7 vector %0d busy cycles", k), nb, ew);
      if (VEC[k].code == 2'd0) model_apply(b, c, a);
      probe(b - 1, $sformatf("R4 R6 vector %0d before start", k));
      probe(b, $sformatf("R4 R6 vector %0d start", k));
      probe(b + c - 1, $sformatf("R6 vector %0d last", k));
      probe(b + c, $sformatf("R6 vector %0d after end", k));
    end
    probe(20000, "R4 far event denied after first allow");
    probe(46, "R6 deny cleared bit");

    do_id(1'b0, '1, w, v);
    chk(v && w == model_id(1'b0, '1), "R10 word0 masked", w, model_id(1'b0, '1));
    do_id(1'b1, '1, w, v);
    chk(v && w == model_id(1'b1, '1), "R10 word1 masked with high range", w, model_id(1'b1, '1));
    do_id(1'b0, 64'h0, w, v);
    chk(v && w == model_id(1'b0, 64'h0), "R9 chain bit still masked by filter", w, model_id(1'b0, 64'h0));

    run_started = 1'b1;
    do_cmd(200, 4, 0, code, nb);
    chk(code == 2, "R3 refused with filter present", code, 2);
    run_started = 1'b0;
    probe(201, "R3 refused command changed nothing");

    do_reset();
    do_cmd(5, 3, 1, code, nb);
    chk(code == 0, "R5 first deny accepted", code, 0);
    chk(nb == WORDS, "R7 first command rewrites every word", nb, WORDS);
    model_apply(5, 3, 1);
    probe(4, "R5 below range permitted");
    probe(5, "R5 range start denied");
    probe(7, "R5 range end denied");
    probe(8, "R5 above range permitted");
    probe(NUM_EV - 1, "R5 last event permitted");
    do_id(1'b0, 64'h0000_0001_0000_00F0, w, v);
    chk(v && w == model_id(1'b0, 64'h0000_0001_0000_00F0), "R10 word0 after deny", w,
        model_id(1'b0, 64'h0000_0001_0000_00F0));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule